// File: doc/BRIEF.md
# Configuration Stream Loader

This block accepts configuration data as a stream of 32-bit words, at most one per clock when `in_valid` is high, and turns it into frame writes on a configuration memory port. Until it sees a synchronization word it discards everything. Once synchronized, it requires a device-identification packet that names this device. Only then will it accept a frame-data packet and store frame contents.

Frame words are gathered in a frame buffer. Each full frame goes to the memory port as one wide write as soon as it fills. A CRC-32 runs over every word after the synchronization word. The stream must end with a CRC word that matches the running value and then a trailer word. Only after both does `done` rise, and until then the device stays in configuration mode.

Any malformed word after sync moves the loader into a sticky error state. Examples are a wrong opcode, a foreign device ID, an illegal word count, a wrong CRC or a wrong trailer. That state holds until reset. Nothing that arrives before the identity check passes can produce a memory write.

Top module: `cfg_stream_loader`

## Requirements
- R1: After synchronous reset, `done`, `error` and `wr_en` are low and the loader hunts for the sync word.
- R2: While hunting, every word other than `SYNC_WORD` (default 32'hAA995566, matched whole and word-aligned) is ignored and leaves no trace. This includes words that look like headers. A later valid stream loads normally.
- R3: A sync word followed by all-ones words produces no write and sets `error`. The all-ones word carries opcode 4'hF in bits [31:28], which is not a valid identification header.
- R4: The first word after sync must carry opcode 4'h1 in bits [31:28]. The next word must equal `DEVICE_ID`. On any mismatch `error` is set and no frame is ever written.
- R5: The following word must carry opcode 4'h2 in bits [31:28] and a word count in bits [15:0]. The count must be nonzero and a multiple of `FRAME_WORDS`. Otherwise `error` is set.
- R6: Each full frame is written the cycle after its last word is accepted, without waiting for the end of the stream. `wr_en` is high for exactly one cycle, and frame word k sits in `wr_data[32k+31:32k]`, with word 0 being the first one received.
- R7: The first write after reset goes to address 0. The address rises by one after each write.
- R8: The CRC is CRC-32 with polynomial 0x04C11DB7. It starts at 32'hFFFFFFFF, shifts each word in MSB first, and applies neither reflection nor a final XOR. It covers the identification header through the last data word. The word after the data must equal it, or `error` is set.
- R9: After a good CRC, the next word must equal `TRAILER_WORD` (default 32'h30000000). `done` rises the cycle after it is accepted. Any other word sets `error`. `done` and `error` are never high together.
- R10: `error` and `done` are sticky until reset. While either is set, all input is ignored and causes no write, including a fresh sync word and a complete valid stream.
- R11: A stream that stops partway through a frame writes nothing for that frame and leaves `done` low.
- R12: Beats with `in_valid` low have no effect, so gaps may appear anywhere in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 32 | Configuration stream word |
| wr_en | output | 1 | Frame write strobe, one cycle per frame |
| wr_addr | output | ADDR_W | Frame address of the write |
| wr_data | output | FRAME_WORDS*32 | Assembled frame, word 0 in the low bits |
| done | output | 1 | Stream loaded, CRC and trailer accepted |
| error | output | 1 | Stream rejected, held until reset |

## Verification
Good streams of one to four frames are swept. Each is preceded by junk that contains header-like words and all-ones, and gaps are inserted in the stream. These runs separate correct frame packing and address stepping from off-by-one slot or address errors, and show that the CRC matches. Sync followed by all-ones, a wrong device ID, counts of zero or non-multiple length, a wrong CRC and a wrong trailer each fail at a different gate. The wrong-CRC case also shows that frames were already committed before the check. A truncated stream and a full stream replayed after `done` or after an error must produce no write, which shows that the sticky states and the partial-frame rule hold.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int unsigned WORD_W = 32;

    localparam logic [3:0] OP_DEVID = 4'h1;
    localparam logic [3:0] OP_FRAME = 4'h2;

    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    typedef enum logic [3:0] {
        LD_HUNT,
        LD_ID_HDR,
        LD_ID_VAL,
        LD_FR_HDR,
        LD_FR_DATA,
        LD_CRC,
        LD_TRAIL,
        LD_DONE,
        LD_FAIL
    } ld_state_e;

    typedef struct packed {
        logic [3:0]  opcode;
        logic [11:0] spare;
        logic [15:0] count;
    } pkt_hdr_t;

    // Shift one word into the running CRC, most significant bit first.
    function automatic logic [WORD_W-1:0] crc32_step(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] w
    );
        logic [WORD_W-1:0] c;
        logic              fb;
        c = cur;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[WORD_W-1] ^ w[i];
            c  = {c[WORD_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/cfgld_crc.sv
module cfgld_crc
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] crc
);
    logic [WORD_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= CRC_SEED;
        else if (en)    crc_q <= crc32_step(crc_q, word);
    end

    assign crc = crc_q;

    // R8: a restart always lands on the seed value
    p_seed_on_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> crc == CRC_SEED);
endmodule

// File: rtl/cfgld_frame_buf.sv
module cfgld_frame_buf
    import cfgld_pkg::*;
#(
    parameter int unsigned FRAME_WORDS = 8,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          data_en,
    input  logic [WORD_W-1:0]             word,
    output logic                          wr_en,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [FRAME_WORDS*WORD_W-1:0] wr_data
);
    localparam int unsigned IDX_W = (FRAME_WORDS > 2) ? $clog2(FRAME_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    logic [FRAME_WORDS-2:0][WORD_W-1:0] slot_q;
    logic [FRAME_WORDS-1:0][WORD_W-1:0] out_q;
    logic [IDX_W-1:0]                   idx_q;
    logic                               wr_q;
    logic [ADDR_W-1:0]                  addr_q;
    logic                               last_beat;

    assign last_beat = data_en && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst)            idx_q <= '0;
        else if (last_beat) idx_q <= '0;
        else if (data_en)   idx_q <= idx_q + 1'b1;
    end

    // One holding register per early word of the frame.
    for (genvar g = 0; g < FRAME_WORDS - 1; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                  slot_q[g] <= '0;
            else if (data_en && idx_q == IDX_W'(g))   slot_q[g] <= word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (last_beat) begin
            for (int k = 0; k < FRAME_WORDS - 1; k++) out_q[k] <= slot_q[k];
            out_q[FRAME_WORDS-1] <= word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            wr_q <= last_beat;
            if (wr_q) addr_q <= addr_q + 1'b1;
        end
    end

    assign wr_en   = wr_q;
    assign wr_addr = addr_q;
    assign wr_data = out_q;

    // R6: a frame commit strobe lasts exactly one cycle
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    // R7: the frame address steps by one after each commit
    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wr_addr == $past(wr_addr) + 1'b1);
    // R6: a commit follows a data beat in the previous cycle
    p_commit_after_data_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(data_en));
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
#(
    parameter logic [WORD_W-1:0] SYNC_WORD    = 32'hAA995566,
    parameter logic [WORD_W-1:0] DEVICE_ID    = 32'h0A5C1234,
    parameter logic [WORD_W-1:0] TRAILER_WORD = 32'h30000000,
    parameter int unsigned       FRAME_WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] crc_val,
    output logic              crc_clr,
    output logic              crc_en,
    output logic              data_en,
    output logic              done,
    output logic              error
);
    ld_state_e   state_q, state_d;
    logic [15:0] rem_q, rem_d;
    pkt_hdr_t    hdr;
    logic        count_ok;

    assign hdr      = pkt_hdr_t'(in_word);
    assign count_ok = (hdr.count != 16'd0) &&
                      ((hdr.count % 16'(FRAME_WORDS)) == 16'd0);

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        data_en = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                LD_HUNT: begin
                    if (in_word == SYNC_WORD) begin
                        crc_clr = 1'b1;
                        state_d = LD_ID_HDR;
                    end
                end
                LD_ID_HDR: begin
                    crc_en  = 1'b1;
                    state_d = (hdr.opcode == OP_DEVID) ? LD_ID_VAL : LD_FAIL;
                end
                LD_ID_VAL: begin
                    crc_en  = 1'b1;
                    state_d = (in_word == DEVICE_ID) ? LD_FR_HDR : LD_FAIL;
                end
                LD_FR_HDR: begin
                    crc_en = 1'b1;
                    if (hdr.opcode == OP_FRAME && count_ok) begin
                        rem_d   = hdr.count;
                        state_d = LD_FR_DATA;
                    end else begin
                        state_d = LD_FAIL;
                    end
                end
                LD_FR_DATA: begin
                    crc_en  = 1'b1;
                    data_en = 1'b1;
                    rem_d   = rem_q - 16'd1;
                    if (rem_q == 16'd1) state_d = LD_CRC;
                end
                LD_CRC: begin
                    state_d = (in_word == crc_val) ? LD_TRAIL : LD_FAIL;
                end
                LD_TRAIL: begin
                    state_d = (in_word == TRAILER_WORD) ? LD_DONE : LD_FAIL;
                end
                LD_DONE: state_d = LD_DONE;
                LD_FAIL: state_d = LD_FAIL;
                default: state_d = LD_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_HUNT;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    assign done  = (state_q == LD_DONE);
    assign error = (state_q == LD_FAIL);

    // R2: non-sync words seen while hunting keep the loader hunting
    p_hunt_ignores_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == LD_HUNT && (!in_valid || in_word != SYNC_WORD))
        |=> state_q == LD_HUNT);
    // R10: failure is held until reset
    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        error |=> error);
    // R10: completion is held until reset
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    // R12: an idle beat never moves the loader
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state_q));
    // R4: frame data is only taken after the identity checks
    p_data_after_id_r4: assert property (@(posedge clk) disable iff (rst)
        data_en |-> state_q == LD_FR_DATA);
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgld_pkg::*;
#(
    parameter logic [31:0] SYNC_WORD    = 32'hAA995566,
    parameter logic [31:0] DEVICE_ID    = 32'h0A5C1234,
    parameter logic [31:0] TRAILER_WORD = 32'h30000000,
    parameter int unsigned FRAME_WORDS  = 8,
    parameter int unsigned ADDR_W       = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [31:0]               in_word,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [FRAME_WORDS*32-1:0] wr_data,
    output logic                      done,
    output logic                      error
);
    logic              crc_clr;
    logic              crc_en;
    logic              data_en;
    logic [WORD_W-1:0] crc_val;

    cfgld_ctrl #(
        .SYNC_WORD   (SYNC_WORD),
        .DEVICE_ID   (DEVICE_ID),
        .TRAILER_WORD(TRAILER_WORD),
        .FRAME_WORDS (FRAME_WORDS)
    ) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_word (in_word),
        .crc_val (crc_val),
        .crc_clr (crc_clr),
        .crc_en  (crc_en),
        .data_en (data_en),
        .done    (done),
        .error   (error)
    );

    cfgld_crc crc_i (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .word(in_word),
        .crc (crc_val)
    );

    cfgld_frame_buf #(
        .FRAME_WORDS(FRAME_WORDS),
        .ADDR_W     (ADDR_W)
    ) fbuf_i (
        .clk    (clk),
        .rst    (rst),
        .data_en(data_en),
        .word   (in_word),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    // R9: completion and failure exclude each other
    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
    // R10: no memory write once the outcome is decided
    p_no_write_when_settled_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !error && !done);
endmodule

// File: tb/cfg_stream_loader_tb_top.sv
module cfg_stream_loader_tb_top;
    localparam logic [31:0] SYNC = 32'hAA995566;
    localparam logic [31:0] DEVID = 32'h0A5C1234;
    localparam logic [31:0] TRL  = 32'h30000000;
    localparam int FW = 8;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [FW*32-1:0] wr_data;
    logic done, error;

    int checks = 0;
    int errors = 0;
    int wr_total = 0;
    logic [FW*32-1:0] cap_data [0:15];
    logic [AW-1:0]    cap_addr [0:15];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_stream_loader dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .error(error)
    );

    // Write monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst && wr_en === 1'b1) begin
            cap_data[wr_total % 16] = wr_data;
            cap_addr[wr_total % 16] = wr_addr;
            wr_total = wr_total + 1;
        end
    end

    task automatic chk(input string req, input logic [FW*32-1:0] act,
                       input logic [FW*32-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            if (r[31] ^ w[i]) r = (r << 1) ^ 32'h04C11DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] dword(input int seed, input int k);
        return {8'hC5, 8'(seed), 16'(k)} ^ 32'h00A50000;
    endfunction

    function automatic logic [FW*32-1:0] exp_frame(input int seed, input int f);
        logic [FW*32-1:0] r;
        for (int j = 0; j < FW; j++) r[j*32 +: 32] = dword(seed, f * FW + j);
        return r;
    endfunction

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'hDEADBEEF;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        idle(2);
        rst = 1'b0;
    endtask

    // Sends a stream; trunc >= 0 stops after that many data words.
    task automatic run_stream(input int nfr, input logic [31:0] id,
                              input bit bad_crc, input bit bad_trl,
                              input int seed, input int trunc);
        logic [31:0] c;
        logic [31:0] w;
        send(SYNC);
        c = 32'hFFFFFFFF;
        w = 32'h10000000;            c = crc_ref(c, w); send(w);
        w = id;                      c = crc_ref(c, w); send(w);
        w = {4'h2, 12'h000, 16'(nfr * FW)}; c = crc_ref(c, w); send(w);
        for (int k = 0; k < nfr * FW; k++) begin
            if (trunc >= 0 && k == trunc) return;
            w = dword(seed, k);
            c = crc_ref(c, w);
            send(w);
            if (k % 3 == 0) idle(1);   // R12: gaps inside the stream
        end
        send(bad_crc ? (c ^ 32'h1) : c);
        send(bad_trl ? (TRL ^ 32'h1) : TRL);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        do_reset();
        // R1: reset state
        chk("R1 done", done, 0);
        chk("R1 error", error, 0);
        chk("R1 wr_en", wr_en, 0);

        // Sweep of good streams, 1..4 frames, with junk before sync.
        for (int n = 1; n <= 4; n++) begin
            do_reset();
            base = wr_total;
            send(32'h10000000); send(32'h20000008); send(32'hFFFFFFFF);
            send(DEVID); idle(2);
            chk("R2 junk ignored writes", 256'(wr_total - base), 0);
            chk("R2 junk ignored error", error, 0);
            run_stream(n, DEVID, 0, 0, n, -1);
            chk("R9 done after trailer", done, 1);
            chk("R9 no error", error, 0);
            chk("R6 frame count", 256'(wr_total - base), 256'(n));
            for (int f = 0; f < n; f++) begin
                chk("R6 frame data", cap_data[(base + f) % 16], exp_frame(n, f));
                chk("R7 frame addr", 256'(cap_addr[(base + f) % 16]), 256'(f));
            end
        end

        // R10: replay after done is ignored
        base = wr_total;
        run_stream(2, DEVID, 0, 0, 9, -1);
        idle(2);
        chk("R10 no write after done", 256'(wr_total - base), 0);
        chk("R10 done held", done, 1);

        // R3: sync then all-ones
        do_reset();
        base = wr_total;
        send(SYNC);
        for (int i = 0; i < 20; i++) send(32'hFFFFFFFF);
        idle(3);
        chk("R3 no write", 256'(wr_total - base), 0);
        chk("R3 error", error, 1);
        chk("R3 not done", done, 0);

        // R4: wrong device ID, then R10 valid stream still ignored
        do_reset();
        base = wr_total;
        run_stream(1, DEVID ^ 32'h100, 0, 0, 3, -1);
        idle(2);
        chk("R4 no write", 256'(wr_total - base), 0);
        chk("R4 error", error, 1);
        run_stream(1, DEVID, 0, 0, 3, -1);
        idle(2);
        chk("R10 no write after error", 256'(wr_total - base), 0);
        chk("R10 error held", error, 1);
        chk("R10 not done", done, 0);

        // R5: count not a multiple of frame length
        do_reset();
        send(SYNC); send(32'h10000000); send(DEVID); send(32'h2000000C);
        chk("R5 bad count error", error, 1);
        // R5: zero count
        do_reset();
        send(SYNC); send(32'h10000000); send(DEVID); send(32'h20000000);
        chk("R5 zero count error", error, 1);
        // R5: wrong opcode on frame header
        do_reset();
        send(SYNC); send(32'h10000000); send(DEVID); send(32'h30000008);
        chk("R5 bad opcode error", error, 1);

        // R11: truncated stream
        do_reset();
        base = wr_total;
        run_stream(2, DEVID, 0, 0, 5, 5);
        idle(10);
        chk("R11 no write", 256'(wr_total - base), 0);
        chk("R11 not done", done, 0);
        chk("R11 no error", error, 0);

        // R8: bad CRC, frames already committed, address restarts at 0
        do_reset();
        base = wr_total;
        run_stream(2, DEVID, 1, 0, 7, -1);
        chk("R8 error on bad crc", error, 1);
        chk("R8 not done", done, 0);
        chk("R6 frames written early", 256'(wr_total - base), 2);
        chk("R7 addr restarts", 256'(cap_addr[base % 16]), 0);
        chk("R6 data before crc", cap_data[(base + 1) % 16], exp_frame(7, 1));

        // R9: bad trailer
        do_reset();
        run_stream(1, DEVID, 0, 1, 4, -1);
        chk("R9 error on bad trailer", error, 1);
        chk("R9 not done", done, 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule